// File: doc/BRIEF.md
# Boot Vector Sequencer

This block brings a processor core out of reset. An active-low reset pin is passed through a two-stage synchroniser. The block accepts it as a real reset only after the synchronised level has stayed low for a minimum number of clocks. Low pulses shorter than that are ignored.

While an accepted reset is in force, the block raises a load strobe and presents the start-up values for the core:
- the stack pointer,
- the three status-register fields (interrupt mask, mode bit, register bank),
- the system clock selection.

Once the pin returns high, the block reads a three-byte start address from a fixed area at the top of the address space. It uses a byte-wide read port with a ready handshake. It packs the three bytes low-byte-first into a 24-bit program counter and then gives the core a single-cycle start pulse.

A separate power-on reset (`por_n`) clears only the block's own flops. It puts the block in the same state as an accepted reset. The block has no write path, so it cannot alter memory or any core register other than the values it presents.

Top module: `boot_vector_seq`

## Requirements
- R1: An accepted reset requires `ext_rst_n` to be sampled low on at least MIN_LOW (10) consecutive rising clock edges. A shorter low pulse is ignored: `init_load` stays 0 and a running core keeps `core_hold` at 0.
- R2: While an accepted reset is in force, `init_load` and `core_hold` are 1 and `mem_rd` is 0. This starts from the cycle after acceptance and lasts until the synchronised pin is high again.
- R3: With `init_load` at 1, `sp_val` equals 0x100. With `init_load` at 0, `sp_val` is 0.
- R4: With `init_load` at 1, the status outputs are as follows, and all three are 0 otherwise:
  - `sr_imask` is 3'b111 (all levels up to 7 masked).
  - `sr_max` is 1 (maximum mode).
  - `sr_bank` is 3'b000 (bank 0).
- R5: With `init_load` at 1, `clk_sel` is 2'b01, the code for oscillator divided by 2. It is 2'b00 otherwise.
- R6: After release, the block makes exactly three reads, at 0xFFFF00, 0xFFFF01 and 0xFFFF02, in that order. Only one read is outstanding at a time. `mem_rd` and `mem_addr` hold steady until a cycle with `mem_rdy` at 1 completes the read.
- R7: `pc_out[7:0]` takes the byte read at 0xFFFF00, `pc_out[15:8]` the byte from 0xFFFF01, and `pc_out[23:16]` the byte from 0xFFFF02.
- R8: `core_start` is 1 for exactly one cycle, the cycle after the third read completes. `pc_out` is valid then and holds afterwards. `core_hold` falls in the cycle after the pulse.
- R9: An accepted reset during the fetch abandons it with no start pulse. After the next release the fetch restarts from 0xFFFF00.
- R10: With `por_n` low, the block is in the accepted-reset state of R2 to R5. When `por_n` rises with the pin high, the fetch of R6 begins without any further reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset of the sequencer's own flops, active low |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| mem_rd | output | 1 | Read request, held until ready |
| mem_addr | output | 24 | Read byte address |
| mem_rdata | input | 8 | Read data, valid when mem_rdy is 1 |
| mem_rdy | input | 1 | Read completion |
| core_hold | output | 1 | Keeps the core stalled until it is started |
| core_start | output | 1 | One-cycle start pulse with pc_out valid |
| pc_out | output | 24 | Assembled start address |
| init_load | output | 1 | Core register initial values valid |
| sp_val | output | 32 | Stack pointer initial value |
| sr_imask | output | 3 | Interrupt mask field initial value |
| sr_max | output | 1 | Mode bit initial value |
| sr_bank | output | 3 | Register bank field initial value |
| clk_sel | output | 2 | Clock select initial value |

## Verification
The hardest case to reach from the ports is a reset accepted partway through the fetch. It must arrive after at least one byte has been taken but before the third completes, so that a half-built program counter has to be abandoned. The stimulus stretches the memory latency to a fixed ten cycles and waits until the first read has been served. It then holds the pin low long enough to be accepted and swaps the vector bytes. It finally expects a single start pulse carrying only the new bytes, with a read trace that begins again at the lowest vector address. A glitch of six clocks during a slow fetch, and pulses of exactly nine and ten clocks, pin down the acceptance boundary.

// File: rtl/boot_pkg.sv
package boot_pkg;

  typedef enum logic [1:0] {
    LD_HOLD,
    LD_FETCH,
    LD_START,
    LD_RUN
  } ld_state_e;

  localparam logic [2:0] IMASK_ALL  = 3'b111;
  localparam logic       MODE_MAX   = 1'b1;
  localparam logic [2:0] BANK_ZERO  = 3'b000;
  localparam logic [1:0] CLK_HALF   = 2'b01;

  // place byte b into lane 'slot' of an accumulator (lane 0 = bits 7:0)
  function automatic logic [63:0] merge_byte(logic [63:0] acc, int unsigned slot,
                                             logic [7:0] b);
    logic [63:0] r;
    r = acc;
    r[slot*8 +: 8] = b;
    return r;
  endfunction

  // byte address of vector lane 'slot'
  function automatic logic [63:0] slot_addr(logic [63:0] base, int unsigned slot);
    return base + 64'(slot);
  endfunction

endpackage

// File: rtl/ldr_rst_filter.sv
module ldr_rst_filter #(
  parameter int MIN_LOW = 10
) (
  input  logic clk,
  input  logic por_n,
  input  logic ext_rst_n,
  output logic sync_n,
  output logic qual
);
  localparam int CW = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] FULL = CW'(MIN_LOW);

  logic [1:0]    sh_q;
  logic [CW-1:0] cnt_q;

  // power-on counts as an accepted reset: chain low, counter full
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      sh_q  <= 2'b00;
      cnt_q <= FULL;
    end else begin
      sh_q <= {sh_q[0], ext_rst_n};
      if (sh_q[1])
        cnt_q <= '0;
      else if (cnt_q != FULL)
        cnt_q <= cnt_q + CW'(1);
    end
  end

  assign sync_n = sh_q[1];
  assign qual   = (cnt_q == FULL);

endmodule

// File: rtl/ldr_fetch.sv
module ldr_fetch
  import boot_pkg::*;
#(
  parameter int                ADDR_W   = 24,
  parameter int                NBYTES   = 3,
  parameter logic [ADDR_W-1:0] VEC_BASE = 24'hFFFF00,
  localparam int               PC_W     = 8 * NBYTES
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              qual,
  input  logic              sync_n,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_rdy,
  output logic [PC_W-1:0]   pc_out,
  output logic              core_start,
  output logic              core_hold,
  output logic              init_load,
  output logic              take,
  output logic              last_take
);
  localparam int IW = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [IW-1:0] LAST = IW'(NBYTES - 1);

  ld_state_e     st_q, st_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [PC_W-1:0] pc_q;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    if (qual) begin
      st_d  = LD_HOLD;
      idx_d = '0;
    end else begin
      case (st_q)
        LD_HOLD:  if (sync_n) begin
                    st_d  = LD_FETCH;
                    idx_d = '0;
                  end
        LD_FETCH: if (mem_rdy) begin
                    if (idx_q == LAST) st_d = LD_START;
                    else               idx_d = idx_q + IW'(1);
                  end
        LD_START: st_d = LD_RUN;
        default:  st_d = st_q;
      endcase
    end
  end

  assign take      = (st_q == LD_FETCH) && mem_rdy && !qual;
  assign last_take = take && (idx_q == LAST);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st_q  <= LD_HOLD;
      idx_q <= '0;
      pc_q  <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      if (take)
        pc_q <= PC_W'(merge_byte(64'(pc_q), 32'(idx_q), mem_rdata));
    end
  end

  assign mem_rd     = (st_q == LD_FETCH);
  assign mem_addr   = ADDR_W'(slot_addr(64'(VEC_BASE), 32'(idx_q)));
  assign pc_out     = pc_q;
  assign core_start = (st_q == LD_START);
  assign core_hold  = (st_q != LD_RUN);
  assign init_load  = (st_q == LD_HOLD);

endmodule

// File: rtl/ldr_init_values.sv
module ldr_init_values
  import boot_pkg::*;
#(
  parameter int              SP_W    = 32,
  parameter logic [SP_W-1:0] SP_INIT = 32'h100
) (
  input  logic            load,
  output logic [SP_W-1:0] sp_val,
  output logic [2:0]      sr_imask,
  output logic            sr_max,
  output logic [2:0]      sr_bank,
  output logic [1:0]      clk_sel
);
  assign sp_val   = load ? SP_INIT   : '0;
  assign sr_imask = load ? IMASK_ALL : 3'b000;
  assign sr_max   = load ? MODE_MAX  : 1'b0;
  assign sr_bank  = load ? BANK_ZERO : 3'b000;
  assign clk_sel  = load ? CLK_HALF  : 2'b00;
endmodule

// File: rtl/boot_vector_seq.sv
module boot_vector_seq #(
  parameter int                MIN_LOW  = 10,
  parameter int                ADDR_W   = 24,
  parameter int                NBYTES   = 3,
  parameter logic [ADDR_W-1:0] VEC_BASE = 24'hFFFF00,
  parameter int                SP_W     = 32,
  parameter logic [SP_W-1:0]   SP_INIT  = 32'h100,
  localparam int               PC_W     = 8 * NBYTES
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              ext_rst_n,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_rdy,
  output logic              core_hold,
  output logic              core_start,
  output logic [PC_W-1:0]   pc_out,
  output logic              init_load,
  output logic [SP_W-1:0]   sp_val,
  output logic [2:0]        sr_imask,
  output logic              sr_max,
  output logic [2:0]        sr_bank,
  output logic [1:0]        clk_sel
);
  // named internal events, observed by the bound checker
  logic rst_qual_w;
  logic sync_n_w;
  logic take_w;
  logic last_take_w;

  ldr_rst_filter #(.MIN_LOW(MIN_LOW)) u_filt (
    .clk       (clk),
    .por_n     (por_n),
    .ext_rst_n (ext_rst_n),
    .sync_n    (sync_n_w),
    .qual      (rst_qual_w)
  );

  ldr_fetch #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .VEC_BASE(VEC_BASE)) u_fetch (
    .clk        (clk),
    .por_n      (por_n),
    .qual       (rst_qual_w),
    .sync_n     (sync_n_w),
    .mem_rd     (mem_rd),
    .mem_addr   (mem_addr),
    .mem_rdata  (mem_rdata),
    .mem_rdy    (mem_rdy),
    .pc_out     (pc_out),
    .core_start (core_start),
    .core_hold  (core_hold),
    .init_load  (init_load),
    .take       (take_w),
    .last_take  (last_take_w)
  );

  ldr_init_values #(.SP_W(SP_W), .SP_INIT(SP_INIT)) u_init (
    .load     (init_load),
    .sp_val   (sp_val),
    .sr_imask (sr_imask),
    .sr_max   (sr_max),
    .sr_bank  (sr_bank),
    .clk_sel  (clk_sel)
  );

endmodule

// File: rtl/boot_seq_chk.sv
module boot_seq_chk #(
  parameter int                MIN_LOW  = 10,
  parameter int                ADDR_W   = 24,
  parameter int                NBYTES   = 3,
  parameter logic [ADDR_W-1:0] VEC_BASE = 24'hFFFF00
) (
  input logic              clk,
  input logic              por_n,
  input logic              ext_rst_n,
  input logic              mem_rd,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rdy,
  input logic              core_start,
  input logic              core_hold,
  input logic              init_load,
  input logic              rst_qual_w,
  input logic              last_take_w
);
  localparam int CW = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] FULL = CW'(MIN_LOW);

  // independent run-length of the raw pin
  logic [CW-1:0] raw_cnt;
  logic          long_ok;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      raw_cnt <= '0;
      long_ok <= 1'b0;
    end else begin
      if (ext_rst_n)            raw_cnt <= '0;
      else if (raw_cnt != FULL) raw_cnt <= raw_cnt + CW'(1);
      if (init_load)                                 long_ok <= 1'b0;
      else if (!ext_rst_n && raw_cnt == FULL - CW'(1)) long_ok <= 1'b1;
    end
  end

  assert_long_low_R1: assert property (@(posedge clk) disable iff (!por_n)
    $rose(init_load) |-> long_ok);

  assert_hold_entry_R2: assert property (@(posedge clk) disable iff (!por_n)
    rst_qual_w |=> (init_load && core_hold && !mem_rd));

  assert_quiet_in_reset_R2: assert property (@(posedge clk) disable iff (!por_n)
    init_load |-> (!mem_rd && !core_start));

  assert_addr_window_R6: assert property (@(posedge clk) disable iff (!por_n)
    mem_rd |-> ((mem_addr - VEC_BASE) < ADDR_W'(NBYTES)));

  assert_req_held_R6: assert property (@(posedge clk) disable iff (!por_n)
    (mem_rd && !mem_rdy && !rst_qual_w) |=> (mem_rd && $stable(mem_addr)));

  assert_ascending_R6: assert property (@(posedge clk) disable iff (!por_n)
    (mem_rd && mem_rdy && !last_take_w && !rst_qual_w) |=>
      (mem_rd && mem_addr == $past(mem_addr) + ADDR_W'(1)));

  assert_start_after_last_R8: assert property (@(posedge clk) disable iff (!por_n)
    core_start |-> $past(last_take_w));

  assert_start_single_R8: assert property (@(posedge clk) disable iff (!por_n)
    core_start |=> !core_start);

  assert_release_core_R8: assert property (@(posedge clk) disable iff (!por_n)
    (core_start && !rst_qual_w) |=> !core_hold);

  assert_abort_R9: assert property (@(posedge clk) disable iff (!por_n)
    rst_qual_w |=> !core_start);

endmodule

bind boot_vector_seq boot_seq_chk #(
  .MIN_LOW(MIN_LOW), .ADDR_W(ADDR_W), .NBYTES(NBYTES), .VEC_BASE(VEC_BASE)
) u_chk (
  .clk         (clk),
  .por_n       (por_n),
  .ext_rst_n   (ext_rst_n),
  .mem_rd      (mem_rd),
  .mem_addr    (mem_addr),
  .mem_rdy     (mem_rdy),
  .core_start  (core_start),
  .core_hold   (core_hold),
  .init_load   (init_load),
  .rst_qual_w  (rst_qual_w),
  .last_take_w (last_take_w)
);

// File: tb/sim_boot_vector_seq.sv
module sim_boot_vector_seq;
  localparam logic [23:0] BASE = 24'hFFFF00;

  logic        clk = 1'b0;
  logic        por_n;
  logic        ext_rst_n;
  logic        mem_rd;
  logic [23:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic        mem_rdy;
  logic        core_hold, core_start, init_load, sr_max;
  logic [23:0] pc_out;
  logic [31:0] sp_val;
  logic [2:0]  sr_imask, sr_bank;
  logic [1:0]  clk_sel;

  always #4 clk = ~clk;

  boot_vector_seq u0 (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy),
    .core_hold(core_hold), .core_start(core_start), .pc_out(pc_out),
    .init_load(init_load), .sp_val(sp_val), .sr_imask(sr_imask), .sr_max(sr_max),
    .sr_bank(sr_bank), .clk_sel(clk_sel)
  );

  int vectors = 0;
  int fails   = 0;
  logic [7:0]  vb [3];
  int          lat_fix = -1;
  int          lat_left = 0;
  int          start_cnt = 0;
  int          init_seen = 0;
  int          rd_cnt = 0;
  logic [23:0] rd_log [8];
  logic [23:0] last_pc = '0;

  function automatic logic [23:0] exp_pc(logic [7:0] b0, logic [7:0] b1, logic [7:0] b2);
    return 24'(b2) * 24'd65536 + 24'(b1) * 24'd256 + 24'(b0);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // memory model and output monitor, all at the falling edge
  initial begin
    mem_rdy = 1'b0;
    mem_rdata = 8'h00;
    forever begin
      @(negedge clk);
      if (por_n) begin
        if (core_start) begin
          start_cnt++;
          last_pc = pc_out;
        end
        if (init_load) begin
          init_seen++;
          rd_cnt = 0;
        end
      end
      if (mem_rd) begin
        if (lat_left == 0) begin
          int off;
          off = int'(mem_addr - BASE);
          mem_rdy = 1'b1;
          mem_rdata = (off >= 0 && off < 3) ? vb[off] : 8'h00;
          if (rd_cnt < 8) rd_log[rd_cnt] = mem_addr;
          rd_cnt++;
          lat_left = (lat_fix >= 0) ? lat_fix : int'($urandom_range(3));
        end else begin
          mem_rdy = 1'b0;
          lat_left--;
        end
      end else begin
        mem_rdy = 1'b0;
      end
    end
  end

  task automatic pulse_low(int n);
    @(negedge clk);
    ext_rst_n = 1'b0;
    repeat (n) @(negedge clk);
    ext_rst_n = 1'b1;
  endtask

  task automatic wait_start(int prev);
    for (int i = 0; i < 400 && start_cnt == prev; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_boot(string tag, int prev, logic [7:0] b0, logic [7:0] b1,
                            logic [7:0] b2);
    chk({tag, " R8 one start"}, 32'(start_cnt), 32'(prev + 1));
    chk({tag, " R7 pc"}, 32'(last_pc), 32'(exp_pc(b0, b1, b2)));
    chk({tag, " R8 hold released"}, 32'(core_hold), 32'd0);
    chk({tag, " R6 read count"}, 32'(rd_cnt), 32'd3);
    for (int i = 0; i < 3; i++)
      chk({tag, " R6 read order"}, 32'(rd_log[i]), 32'(BASE + 24'(i)));
  endtask

  task automatic boot_with(string tag, int width, logic [7:0] b0, logic [7:0] b1,
                           logic [7:0] b2);
    int prev;
    vb[0] = b0; vb[1] = b1; vb[2] = b2;
    prev = start_cnt;
    pulse_low(width);
    wait_start(prev);
    check_boot(tag, prev, b0, b1, b2);
  endtask

  initial begin
    int prev, prev_init;
    void'($urandom(32'd2024));
    por_n = 1'b0;
    ext_rst_n = 1'b1;
    vb[0] = 8'h34; vb[1] = 8'h12; vb[2] = 8'hAB;
    repeat (3) @(negedge clk);
    // R10 / R2..R5: power-on state
    chk("R10 init_load", 32'(init_load), 32'd1);
    chk("R10 core_hold", 32'(core_hold), 32'd1);
    chk("R2 no read", 32'(mem_rd), 32'd0);
    chk("R3 sp", sp_val, 32'h100);
    chk("R4 imask", 32'(sr_imask), 32'd7);
    chk("R4 max", 32'(sr_max), 32'd1);
    chk("R4 bank", 32'(sr_bank), 32'd0);
    chk("R5 clk_sel", 32'(clk_sel), 32'd1);
    prev = start_cnt;
    por_n = 1'b1;
    wait_start(prev);
    check_boot("R10 boot", prev, 8'h34, 8'h12, 8'hAB);
    chk("R3 sp cleared", sp_val, 32'd0);
    chk("R5 clk_sel cleared", 32'(clk_sel), 32'd0);

    // R1: nine-clock pulse ignored
    prev_init = init_seen;
    prev = start_cnt;
    pulse_low(9);
    repeat (20) @(negedge clk);
    chk("R1 short ignored init", 32'(init_seen), 32'(prev_init));
    chk("R1 short ignored hold", 32'(core_hold), 32'd0);
    chk("R1 short no start", 32'(start_cnt), 32'(prev));
    // R1: exactly ten clocks accepted
    boot_with("R1 ten", 10, 8'h00, 8'hFF, 8'h5A);

    // R2..R5 during a long reset
    @(negedge clk);
    ext_rst_n = 1'b0;
    repeat (25) @(negedge clk);
    chk("R2 init_load held", 32'(init_load), 32'd1);
    chk("R2 core_hold held", 32'(core_hold), 32'd1);
    chk("R2 no read in reset", 32'(mem_rd), 32'd0);
    chk("R3 sp in reset", sp_val, 32'h100);
    chk("R4 imask in reset", 32'(sr_imask), 32'd7);
    chk("R5 clk in reset", 32'(clk_sel), 32'd1);
    vb[0] = 8'hFF; vb[1] = 8'hFF; vb[2] = 8'hFF;
    prev = start_cnt;
    ext_rst_n = 1'b1;
    wait_start(prev);
    check_boot("R2 release", prev, 8'hFF, 8'hFF, 8'hFF);

    // R9: abort mid-fetch
    lat_fix = 10;
    vb[0] = 8'h11; vb[1] = 8'h22; vb[2] = 8'h33;
    prev = start_cnt;
    pulse_low(12);
    repeat (5) @(negedge clk);
    for (int i = 0; i < 100 && rd_cnt < 1; i++) @(negedge clk);
    vb[0] = 8'hC3; vb[1] = 8'h5D; vb[2] = 8'h7E;
    pulse_low(12);
    chk("R9 no start from aborted fetch", 32'(start_cnt), 32'(prev));
    wait_start(prev);
    check_boot("R9 restart", prev, 8'hC3, 8'h5D, 8'h7E);

    // R1: short glitch during a slow fetch is ignored
    lat_fix = 4;
    vb[0] = 8'h9A; vb[1] = 8'h01; vb[2] = 8'h80;
    prev = start_cnt;
    pulse_low(10);
    repeat (5) @(negedge clk);
    for (int i = 0; i < 100 && rd_cnt < 1; i++) @(negedge clk);
    prev_init = init_seen;
    pulse_low(6);
    wait_start(prev);
    chk("R1 glitch no reset", 32'(init_seen), 32'(prev_init));
    check_boot("R1 glitch", prev, 8'h9A, 8'h01, 8'h80);

    // random boots, R6/R7/R8
    lat_fix = -1;
    for (int n = 0; n < 20; n++) begin
      boot_with("R7 random", 10 + int'($urandom_range(15)),
                8'($urandom_range(255)), 8'($urandom_range(255)),
                8'($urandom_range(255)));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule